// File: doc/BRIEF.md
# Shadowed Four-Channel Result Readout Window

This block presents four 16-bit converter results to a host as a read-only window of eight byte registers. Each channel occupies an even/odd byte pair: the even address returns the low byte and the odd address returns the high byte. The converter side delivers all four results at once with a single load strobe, and the block keeps them as live values.

A host bus that moves one byte per access cannot read a 16-bit result in one step. If a new conversion arrived between the two byte reads, the halves would belong to different samples. To prevent this, each channel has a shadow register. A read of a channel's low byte copies that channel's live upper byte into its shadow. A read of the high byte returns the shadow rather than the live value. A word read, meaning a low-byte read followed by the matching high-byte read, is therefore always coherent, even when conversions complete in between.

Read responses are registered. The data appears one cycle after the access, together with a valid flag. A write cycle on the bus is recognised and discarded.

Top module: `chan_shadow_window`

## Requirements
- R1: Address `BASE_ADDR + 2k` returns the low byte and `BASE_ADDR + 2k + 1` the high byte of channel k. Channel k occupies bits `[16k+15:16k]` of `res_data`. With the default base 10h, the channels are: green k=0 (10h/11h), red k=1 (12h/13h), blue k=2 (14h/15h), clear k=3 (16h/17h).
- R2: A cycle with `rd_en=1` and `rd_we=1` is a write. It produces no response (`rd_valid=0` next cycle), captures no shadow, and changes no value that a later read returns.
- R3: After reset, every live value and every shadow is zero, so all eight window bytes read as 00h.
- R4: A low-byte read in cycle t returns, in cycle t+1 with `rd_valid=1`, the low byte of the live result held before the edge that ends cycle t.
- R5: A low-byte read of a channel loads only that channel's shadow. The shadows of the other channels keep their contents.
- R6: A high-byte read returns that channel's shadow, not its live upper byte, even when load strobes arrived after the shadow was captured. With no earlier low-byte read since reset, it returns 00h.
- R7: When `res_valid` is high, live results take `res_data` at the edge, independent of bus activity. A low-byte read in the same cycle returns the pre-update low byte and shadows the pre-update high byte.
- R8: A read outside the eight-byte window returns 00h with `rd_valid=1`.
- R9: `rd_data` is 00h in every cycle in which `rd_valid` is 0.
- R10: A low-byte read of channel k followed in the next cycle by a high-byte read of channel k returns both bytes of one and the same 16-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| res_valid | input | 1 | Load strobe for all live results |
| res_data | input | CHANNELS*2*BYTE_W | Packed results, channel k in slice k |
| rd_en | input | 1 | Bus access request |
| rd_we | input | 1 | Access is a write (discarded) |
| rd_addr | input | ADDR_W | Byte address of the access |
| rd_valid | output | 1 | Read response valid, one cycle after a read |
| rd_data | output | BYTE_W | Read response byte |

## Verification
The bench builds the block with its default parameters: four channels, byte width 8, and a window based at 10h inside an 8-bit address space. With these values, every window address is reachable, and so are the neighbours just below and above the window and the far ends of the address space. A long stretch of random strobes, reads and writes then pushes load strobes between the low and high halves of word reads, into the same cycle as low-byte reads, and across interleaved channels. This exposes any shadow that follows the live value or is captured from the wrong channel.

// File: rtl/chan_shadow_pkg.sv
package chan_shadow_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LOW  = 2'd1,
    ACC_HIGH = 2'd2,
    ACC_MISS = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/rw_addr_decode.sv
module rw_addr_decode
  import chan_shadow_pkg::*;
#(
  parameter int                 ADDR_W    = 8,
  parameter int                 CHANNELS  = 4,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h10,
  localparam int                IDX_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic              rd_en,
  input  logic              rd_we,
  input  logic [ADDR_W-1:0] rd_addr,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * CHANNELS);

  logic [ADDR_W-1:0] offset;
  logic              in_window;

  always_comb begin
    offset    = rd_addr - BASE_ADDR;
    in_window = (rd_addr >= BASE_ADDR) && (offset < SPAN);
    idx_o     = offset[IDX_W:1];
    if (!rd_en || rd_we) begin
      kind_o = ACC_NONE;
    end else if (!in_window) begin
      kind_o = ACC_MISS;
    end else if (offset[0]) begin
      kind_o = ACC_HIGH;
    end else begin
      kind_o = ACC_LOW;
    end
  end

endmodule

// File: rtl/rw_channel_slot.sv
module rw_channel_slot #(
  parameter int  BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cap_i,
  output logic [DATA_W-1:0] live_o,
  output logic [BYTE_W-1:0] shadow_o
);

  logic [DATA_W-1:0] live_q, live_d;
  logic [BYTE_W-1:0] shadow_q, shadow_d;

  // Next-state: the shadow samples the live value as it stands before this edge
  always_comb begin
    live_d   = live_q;
    shadow_d = shadow_q;
    if (load_i) live_d   = res_i;
    if (cap_i)  shadow_d = live_q[DATA_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (load_i) live_q   <= live_d;
      if (cap_i)  shadow_q <= shadow_d;
    end
  end

  assign live_o   = live_q;
  assign shadow_o = shadow_q;

endmodule

// File: rtl/chan_shadow_window.sv
module chan_shadow_window
  import chan_shadow_pkg::*;
#(
  parameter int                CHANNELS  = 4,
  parameter int                BYTE_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         res_valid,
  input  logic [CHANNELS*2*BYTE_W-1:0] res_data,
  input  logic                         rd_en,
  input  logic                         rd_we,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic                         rd_valid,
  output logic [BYTE_W-1:0]            rd_data
);

  localparam int DATA_W = 2 * BYTE_W;
  localparam int IDX_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  acc_kind_e                  kind;
  logic [IDX_W-1:0]           idx;
  logic [CHANNELS-1:0]        cap_vec;
  logic [DATA_W-1:0]          live_arr   [CHANNELS];
  logic [BYTE_W-1:0]          shadow_arr [CHANNELS];
  logic [CHANNELS*DATA_W-1:0] live_flat;

  logic              rd_valid_q, rd_valid_d;
  logic [BYTE_W-1:0] rd_data_q, rd_data_d;

  rw_addr_decode #(
    .ADDR_W   (ADDR_W),
    .CHANNELS (CHANNELS),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .rd_en  (rd_en),
    .rd_we  (rd_we),
    .rd_addr(rd_addr),
    .kind_o (kind),
    .idx_o  (idx)
  );

  for (genvar k = 0; k < CHANNELS; k++) begin : g_slot
    assign cap_vec[k] = (kind == ACC_LOW) && (idx == IDX_W'(k));

    rw_channel_slot #(.BYTE_W(BYTE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (res_valid),
      .res_i   (res_data[k*DATA_W +: DATA_W]),
      .cap_i   (cap_vec[k]),
      .live_o  (live_arr[k]),
      .shadow_o(shadow_arr[k])
    );

    assign live_flat[k*DATA_W +: DATA_W] = live_arr[k];
  end

  // Response selection: low byte from live, high byte from shadow
  always_comb begin
    rd_valid_d = (kind != ACC_NONE);
    case (kind)
      ACC_LOW:  rd_data_d = live_arr[idx][BYTE_W-1:0];
      ACC_HIGH: rd_data_d = shadow_arr[idx];
      default:  rd_data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/chan_shadow_window_chk.sv
module chan_shadow_window_chk #(
  parameter int                CHANNELS  = 4,
  parameter int                BYTE_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
  localparam int               DATA_W    = 2 * BYTE_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         res_valid,
  input logic [CHANNELS*DATA_W-1:0]   res_data,
  input logic                         rd_en,
  input logic                         rd_we,
  input logic [ADDR_W-1:0]            rd_addr,
  input logic                         rd_valid,
  input logic [BYTE_W-1:0]            rd_data,
  input logic [CHANNELS*DATA_W-1:0]   live_flat
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + ADDR_W'(2 * CHANNELS);

  logic is_read, in_win;
  assign is_read = rd_en && !rd_we;
  assign in_win  = (rd_addr >= BASE_ADDR) && (rd_addr < TOP_ADDR);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_we) |=> !rd_valid);

  assert_read_answers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> rd_valid);

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && !in_win) |=> rd_data == '0);

  assert_live_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> live_flat == $past(res_data));

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = BASE_ADDR + ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] HI_A = LO_A + ADDR_W'(1);

    assert_low_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && rd_addr == LO_A) |=> rd_data == $past(live_flat[k*DATA_W +: BYTE_W]));

    assert_word_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && rd_addr == LO_A) ##1 (is_read && rd_addr == HI_A)
        |=> rd_data == $past(live_flat[k*DATA_W+BYTE_W +: BYTE_W], 2));
  end

endmodule

bind chan_shadow_window chan_shadow_window_chk #(
  .CHANNELS (CHANNELS),
  .BYTE_W   (BYTE_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid),
  .res_data (res_data),
  .rd_en    (rd_en),
  .rd_we    (rd_we),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .live_flat(live_flat)
);

// File: tb/tb_chan_shadow_window.sv
`timescale 1ns/1ps
module tb_chan_shadow_window;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [63:0] res_data;
  logic        rd_en, rd_we;
  logic [7:0]  rd_addr;
  logic        rd_valid;
  logic [7:0]  rd_data;

  chan_shadow_window dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .rd_en(rd_en), .rd_we(rd_we), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    armed  = 0;
  string phase  = "";

  // behavioural reference
  int    live   [4];
  int    shadow [4];
  int    prev_low = -1;
  bit    exp_valid;
  int    exp_data;
  string exp_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (live[i]) begin live[i] = 0; shadow[i] = 0; end
      prev_low  = -1;
      exp_valid = 0;
      exp_data  = 0;
      exp_tag   = "R3";
    end else begin
      int a, ch, this_low;
      this_low = -1;
      a = rd_addr;
      if (rd_en && !rd_we) begin
        exp_valid = 1;
        if (a >= 16 && a < 24) begin
          ch = (a - 16) / 2;
          if (a % 2 == 0) begin
            exp_data  = live[ch] & 255;
            shadow[ch] = (live[ch] >> 8) & 255;
            exp_tag   = res_valid ? "R7" : "R4";
            this_low  = ch;
          end else begin
            exp_data = shadow[ch];
            exp_tag  = (prev_low == ch) ? "R10" : "R6";
          end
        end else begin
          exp_data = 0;
          exp_tag  = "R8";
        end
      end else begin
        exp_valid = 0;
        exp_data  = 0;
        exp_tag   = (rd_en && rd_we) ? "R2" : "R9";
      end
      prev_low = this_low;
      if (res_valid)
        for (int c = 0; c < 4; c++) live[c] = int'(res_data[16*c +: 16]);
      if (phase != "") exp_tag = phase;
    end
  end

  always @(negedge clk) begin
    if (armed && rst_n && !done) begin
      checks++;
      if (rd_valid !== exp_valid || int'(rd_data) != exp_data) begin
        errors++;
        $display("FAIL %s: valid=%0b data=%02h expected valid=%0b data=%02h",
                 exp_tag, rd_valid, rd_data, exp_valid, exp_data[7:0]);
      end
    end
  end

  task automatic cyc(input bit en, input bit we, input logic [7:0] a,
                     input bit sv, input logic [63:0] d);
    rd_en = en; rd_we = we; rd_addr = a; res_valid = sv; res_data = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1, 0, a, 0, 64'h0);
  endtask

  task automatic load(input logic [63:0] d);
    cyc(0, 0, 8'h00, 1, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rd_en = 0; rd_we = 0; rd_addr = 0; res_valid = 0; res_data = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R3: reset valid=%0b data=%02h expected valid=0 data=00", rd_valid, rd_data);
    end
    rst_n = 1; armed = 1;

    // R3: every window byte reads zero after reset, high bytes first
    phase = "R3";
    for (int a = 17; a < 24; a += 2) rd(8'(a));
    for (int a = 16; a < 24; a++)    rd(8'(a));
    rd(8'h11);
    // R1: channel placement and byte order
    phase = "R1";
    load(64'hD7C6_B5A4_9382_7160);
    for (int a = 16; a < 24; a++) rd(8'(a));
    phase = "";
    // R10 coherent word reads; R6 high read after a later load
    load(64'h1111_2222_3333_4444);
    for (int c = 0; c < 4; c++) begin rd(8'(16 + 2*c)); rd(8'(17 + 2*c)); end
    rd(8'h14); load(64'hAAAA_BBBB_CCCC_DDDD); rd(8'h15);
    cyc(1, 0, 8'h16, 1, 64'h5A5A_0F0F_F0F0_A5A5); rd(8'h17);   // R7 same-cycle load
    // R5: one channel's capture leaves others alone
    phase = "R5";
    rd(8'h10); rd(8'h12); load(64'h0102_0304_0506_0708); rd(8'h11); rd(8'h13); rd(8'h15);
    // R2: writes are discarded and capture nothing
    phase = "R2";
    load(64'hFEDC_BA98_7654_3210);
    cyc(1, 1, 8'h16, 0, 0); cyc(1, 1, 8'h17, 0, 0); rd(8'h17);
    // R8: outside the window
    phase = "R8";
    rd(8'h0F); rd(8'h18); rd(8'hFF); rd(8'h00);
    phase = "R9";
    cyc(0, 0, 8'h10, 0, 0); cyc(0, 0, 8'h11, 0, 0);
    phase = "";
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'(8'h10 + $urandom % 8);
      cyc($urandom % 4 != 0, $urandom % 6 == 0, a, $urandom % 3 == 0,
          {$urandom, $urandom});
    end
    cyc(0, 0, 8'h00, 0, 0);
    finish_run();
  end

endmodule